// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block runs the command protocol of a parallel NOR flash array on behalf of a host. The flash bus is 32 bits wide and is made of two 16-bit devices side by side, so every command byte is written to both 16-bit halves at once, and every status or identifier word holds one copy for each device. The host asks for one of three operations (identity probe, block erase or single-dword program). The block then issues the fixed series of bus writes and reads for that operation and reports pass or fail.

Each bus access is a one-cycle read or write strobe with an address and write data. The block then waits for the bus to return an acknowledge, which carries read data for reads. Erase and program poll the device status until both devices report ready, or until a configurable number of status reads has gone by. The block then puts both devices back into read-array mode and only after that judges the result. A program operation also reads the word back and compares it with the data written. Only one operation runs at a time.

Top module: `nor_cmd_sequencer`

## Requirements
- R1: After reset, busy, done and pass are low and neither bus strobe is asserted until an operation is accepted.
- R2: Every command write puts the 8-bit code in bits 7:0 and in bits 23:16 with all other bits zero: read array 0xFF, identify 0x90, erase setup 0x20, erase confirm 0xD0, program setup 0x40, read status 0x70 (so identify is 0x00900090).
- R3: A probe (opKind 0) writes identify to address 0, reads address 0 and then address 1, and writes read array to address 0. It passes only if the first read returns 0x00890089 and the second returns 0x88F388F3 or 0x88F488F4.
- R4: An erase (opKind 1) writes erase setup and then erase confirm, both to opAddr, and then starts polling.
- R5: Polling repeats a read-status write followed by a read of opAddr. It stops once bit 7 and bit 23 of the status word are both set. A status word with only one of these bits set keeps it polling.
- R6: When polling ends, for any reason, the block writes read array to the operation address. For every valid operation this is the last write before done.
- R7: An erase fails if bit 5 or bit 21 of the final status word is set.
- R8: A program (opKind 2) writes program setup and then opData to opAddr, polls, writes read array, and reads opAddr once more. It fails if bit 4 or bit 20 of the final status is set, or if that readback differs from opData.
- R9: If POLL_LIMIT status reads have returned not-ready, polling stops, read array is written, no readback is made, and the operation fails.
- R10: Each read or write strobe lasts exactly one cycle, the two strobes never coincide, and no new strobe is issued until the previous access has been acknowledged.
- R11: busy is high from the cycle after an operation is accepted until done. done is a one-cycle pulse with pass valid in that cycle. A request made while busy is ignored.
- R12: opKind 3 is reserved. It produces a done pulse with pass low and no bus access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation request, taken when idle |
| opKind | input | 2 | 0 probe, 1 erase, 2 program, 3 reserved |
| opAddr | input | ADDR_W | Dword address for erase or program |
| opData | input | 32 | Word to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result, valid with done |
| busAddr | output | ADDR_W | Flash bus dword address |
| busWdata | output | 32 | Flash bus write data |
| busWr | output | 1 | One-cycle write request |
| busRd | output | 1 | One-cycle read request |
| busRdata | input | 32 | Read data, valid with busAck |
| busAck | input | 1 | Access completion |

## Verification
A sequencer that is in the wrong state shows up on the bus strobes within one access. It might issue a wrong or missing code, write to the wrong address, skip the return to read-array mode, or strobe again before the acknowledge. So the bench logs every transaction and compares the whole log with a sequence rebuilt from the operation and the behaviour of the simulated device. A wrong poll count or a wrong judgement of status halves appears as a poll sequence of the wrong length or a wrong pass bit at the done pulse. The limit cases are devices that are ready after exactly POLL_LIMIT reads or never, status words with only one half ready or one half in error, and program data that looks like a command code.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  localparam int BUS_W  = 32;
  localparam int HALF_W = 16;
  localparam int HALVES = BUS_W / HALF_W;

  localparam logic [7:0] CODE_ARRAY   = 8'hFF;
  localparam logic [7:0] CODE_IDENT   = 8'h90;
  localparam logic [7:0] CODE_ERASE   = 8'h20;
  localparam logic [7:0] CODE_CONFIRM = 8'hD0;
  localparam logic [7:0] CODE_PROG    = 8'h40;
  localparam logic [7:0] CODE_STATUS  = 8'h70;

  localparam logic [BUS_W-1:0] MANUF_ID  = 32'h0089_0089;
  localparam logic [BUS_W-1:0] DEV_ID_T  = 32'h88F3_88F3;
  localparam logic [BUS_W-1:0] DEV_ID_B  = 32'h88F4_88F4;

  localparam int BIT_READY     = 7;
  localparam int BIT_ERASE_ERR = 5;
  localparam int BIT_PROG_ERR  = 4;

  typedef enum logic [1:0] {
    OP_PROBE   = 2'd0,
    OP_ERASE   = 2'd1,
    OP_PROGRAM = 2'd2,
    OP_RSVD    = 2'd3
  } opKind_e;

  typedef enum logic [2:0] {
    CMD_ARRAY, CMD_IDENT, CMD_ERASE, CMD_CONFIRM, CMD_PROG, CMD_STATUS, CMD_DATA
  } cmdSel_e;

  typedef enum logic [1:0] { ADR_OP, ADR_ZERO, ADR_ONE } adrSel_e;

  typedef enum logic [3:0] {
    S_IDLE, S_ID_CMD, S_ID_MAN, S_ID_DEV, S_ERS_SETUP, S_ERS_CONF,
    S_PGM_SETUP, S_PGM_DATA, S_POLL_CMD, S_POLL_RD, S_POLL_CHK,
    S_RESET, S_VERIFY, S_DONE
  } step_e;

  typedef struct packed {
    logic    load;
    logic    wr;
    logic    rd;
    cmdSel_e cmd;
    adrSel_e adr;
    logic    capStatus;
    logic    capMan;
    logic    capDev;
    logic    capRb;
    logic    setTimeout;
  } ctrlStrobes_t;

  function automatic logic [BUS_W-1:0] dupCode(input logic [7:0] code);
    logic [BUS_W-1:0] w;
    w = '0;
    for (int h = 0; h < HALVES; h++) w[h*HALF_W +: 8] = code;
    return w;
  endfunction

endpackage

// File: rtl/nor_seq_dp.sv
module nor_seq_dp
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int POLL_LIMIT = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      ctl,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [BUS_W-1:0]  opData,
  input  logic [BUS_W-1:0]  busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [BUS_W-1:0]  busWdata,
  output logic              busWr,
  output logic              busRd,
  output logic              statusReady,
  output logic              eraseFault,
  output logic              progFault,
  output logic              verifyMatch,
  output logic              identMatch,
  output logic              pollExpired,
  output logic              timedOut
);

  localparam int CNT_W = $clog2(POLL_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(POLL_LIMIT);

  logic [ADDR_W-1:0] addrReg;
  logic [BUS_W-1:0]  dataReg;
  logic [CNT_W-1:0]  pollCnt;
  logic              readyReg, eraseReg, progReg, manOk, devOk, rbOk, toReg;
  logic [HALVES-1:0] rdyVec, eraseVec, progVec;

  // per-device status bits, one copy in each half of the bus word
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign rdyVec[h]   = busRdata[h*HALF_W + BIT_READY];
    assign eraseVec[h] = busRdata[h*HALF_W + BIT_ERASE_ERR];
    assign progVec[h]  = busRdata[h*HALF_W + BIT_PROG_ERR];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      dataReg  <= '0;
      pollCnt  <= '0;
      readyReg <= 1'b0;
      eraseReg <= 1'b0;
      progReg  <= 1'b0;
      manOk    <= 1'b0;
      devOk    <= 1'b0;
      rbOk     <= 1'b0;
      toReg    <= 1'b0;
    end else begin
      if (ctl.load) begin
        addrReg  <= opAddr;
        dataReg  <= opData;
        pollCnt  <= '0;
        readyReg <= 1'b0;
        eraseReg <= 1'b0;
        progReg  <= 1'b0;
        manOk    <= 1'b0;
        devOk    <= 1'b0;
        rbOk     <= 1'b0;
        toReg    <= 1'b0;
      end
      if (ctl.capStatus) begin
        readyReg <= &rdyVec;
        eraseReg <= |eraseVec;
        progReg  <= |progVec;
        if (pollCnt != CNT_MAX) pollCnt <= pollCnt + 1'b1;
      end
      if (ctl.capMan) manOk <= (busRdata == MANUF_ID);
      if (ctl.capDev) devOk <= (busRdata == DEV_ID_T) || (busRdata == DEV_ID_B);
      if (ctl.capRb) rbOk <= (busRdata == dataReg);
      if (ctl.setTimeout) toReg <= 1'b1;
    end
  end

  always_comb begin
    unique case (ctl.adr)
      ADR_ZERO: busAddr = '0;
      ADR_ONE:  busAddr = ADDR_W'(1);
      default:  busAddr = addrReg;
    endcase
  end

  always_comb begin
    unique case (ctl.cmd)
      CMD_IDENT:   busWdata = dupCode(CODE_IDENT);
      CMD_ERASE:   busWdata = dupCode(CODE_ERASE);
      CMD_CONFIRM: busWdata = dupCode(CODE_CONFIRM);
      CMD_PROG:    busWdata = dupCode(CODE_PROG);
      CMD_STATUS:  busWdata = dupCode(CODE_STATUS);
      CMD_DATA:    busWdata = dataReg;
      default:     busWdata = dupCode(CODE_ARRAY);
    endcase
  end

  assign busWr       = ctl.wr;
  assign busRd       = ctl.rd;
  assign statusReady = readyReg;
  assign eraseFault  = eraseReg;
  assign progFault   = progReg;
  assign verifyMatch = rbOk;
  assign identMatch  = manOk && devOk;
  assign pollExpired = (pollCnt >= CNT_MAX);
  assign timedOut    = toReg;

endmodule

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
  import nor_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         opValid,
  input  logic [1:0]   opKind,
  input  logic         busAck,
  input  logic         statusReady,
  input  logic         eraseFault,
  input  logic         progFault,
  input  logic         verifyMatch,
  input  logic         identMatch,
  input  logic         pollExpired,
  input  logic         timedOut,
  output ctrlStrobes_t ctl,
  output logic         busy,
  output logic         done,
  output logic         pass
);

  step_e   step, stepNext, after;
  opKind_e kind, kindNext;
  logic    waiting, waitNext;
  logic    isBus, isRead, ackNow, result;

  assign ackNow = waiting && busAck;

  always_comb begin
    ctl      = ctrlStrobes_t'('0);
    stepNext = step;
    waitNext = waiting;
    kindNext = kind;
    isBus    = 1'b0;
    isRead   = 1'b0;
    after    = step;
    unique case (step)
      S_IDLE: begin
        if (opValid) begin
          ctl.load = 1'b1;
          kindNext = opKind_e'(opKind);
          waitNext = 1'b0;
          unique case (opKind_e'(opKind))
            OP_PROBE:   stepNext = S_ID_CMD;
            OP_ERASE:   stepNext = S_ERS_SETUP;
            OP_PROGRAM: stepNext = S_PGM_SETUP;
            default:    stepNext = S_DONE;
          endcase
        end
      end
      S_ID_CMD: begin
        isBus = 1'b1; ctl.cmd = CMD_IDENT; ctl.adr = ADR_ZERO; after = S_ID_MAN;
      end
      S_ID_MAN: begin
        isBus = 1'b1; isRead = 1'b1; ctl.adr = ADR_ZERO; ctl.capMan = ackNow;
        after = S_ID_DEV;
      end
      S_ID_DEV: begin
        isBus = 1'b1; isRead = 1'b1; ctl.adr = ADR_ONE; ctl.capDev = ackNow;
        after = S_RESET;
      end
      S_ERS_SETUP: begin
        isBus = 1'b1; ctl.cmd = CMD_ERASE; after = S_ERS_CONF;
      end
      S_ERS_CONF: begin
        isBus = 1'b1; ctl.cmd = CMD_CONFIRM; after = S_POLL_CMD;
      end
      S_PGM_SETUP: begin
        isBus = 1'b1; ctl.cmd = CMD_PROG; after = S_PGM_DATA;
      end
      S_PGM_DATA: begin
        isBus = 1'b1; ctl.cmd = CMD_DATA; after = S_POLL_CMD;
      end
      S_POLL_CMD: begin
        isBus = 1'b1; ctl.cmd = CMD_STATUS; after = S_POLL_RD;
      end
      S_POLL_RD: begin
        isBus = 1'b1; isRead = 1'b1; ctl.capStatus = ackNow; after = S_POLL_CHK;
      end
      S_POLL_CHK: begin
        if (statusReady) begin
          stepNext = S_RESET;
        end else if (pollExpired) begin
          ctl.setTimeout = 1'b1;
          stepNext = S_RESET;
        end else begin
          stepNext = S_POLL_CMD;
        end
      end
      S_RESET: begin
        isBus   = 1'b1;
        ctl.cmd = CMD_ARRAY;
        ctl.adr = (kind == OP_PROBE) ? ADR_ZERO : ADR_OP;
        after   = (kind == OP_PROGRAM && !timedOut) ? S_VERIFY : S_DONE;
      end
      S_VERIFY: begin
        isBus = 1'b1; isRead = 1'b1; ctl.capRb = ackNow; after = S_DONE;
      end
      S_DONE:  stepNext = S_IDLE;
      default: stepNext = S_IDLE;
    endcase

    // shared access handshake: one request cycle, then wait for acknowledge
    if (isBus) begin
      if (!waiting) begin
        ctl.wr   = !isRead;
        ctl.rd   = isRead;
        waitNext = 1'b1;
      end else if (busAck) begin
        waitNext = 1'b0;
        stepNext = after;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step    <= S_IDLE;
      kind    <= OP_PROBE;
      waiting <= 1'b0;
    end else begin
      step    <= stepNext;
      kind    <= kindNext;
      waiting <= waitNext;
    end
  end

  always_comb begin
    unique case (kind)
      OP_PROBE:   result = identMatch;
      OP_ERASE:   result = !timedOut && !eraseFault;
      OP_PROGRAM: result = !timedOut && !progFault && verifyMatch;
      default:    result = 1'b0;
    endcase
  end

  assign busy = (step != S_IDLE);
  assign done = (step == S_DONE);
  assign pass = done && result;

endmodule

// File: rtl/nor_cmd_sequencer.sv
module nor_cmd_sequencer
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int POLL_LIMIT = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [1:0]        opKind,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [31:0]       opData,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] busAddr,
  output logic [31:0]       busWdata,
  output logic              busWr,
  output logic              busRd,
  input  logic [31:0]       busRdata,
  input  logic              busAck
);

  ctrlStrobes_t ctl;
  logic statusReady, eraseFault, progFault, verifyMatch, identMatch, pollExpired, timedOut;

  nor_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind), .busAck(busAck),
    .statusReady(statusReady), .eraseFault(eraseFault), .progFault(progFault),
    .verifyMatch(verifyMatch), .identMatch(identMatch), .pollExpired(pollExpired),
    .timedOut(timedOut), .ctl(ctl), .busy(busy), .done(done), .pass(pass)
  );

  nor_seq_dp #(.ADDR_W(ADDR_W), .POLL_LIMIT(POLL_LIMIT)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opAddr(opAddr), .opData(opData),
    .busRdata(busRdata), .busAddr(busAddr), .busWdata(busWdata), .busWr(busWr),
    .busRd(busRd), .statusReady(statusReady), .eraseFault(eraseFault),
    .progFault(progFault), .verifyMatch(verifyMatch), .identMatch(identMatch),
    .pollExpired(pollExpired), .timedOut(timedOut)
  );

endmodule

// File: rtl/nor_seq_checker.sv
module nor_seq_checker #(
  parameter int ADDR_W     = 20,
  parameter int POLL_LIMIT = 1000
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [1:0]        opKind,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic              busWr,
  input logic              busRd,
  input logic              busAck
);

  localparam int CNT_W = $clog2(POLL_LIMIT + 2);
  localparam logic [31:0] W_ARRAY   = 32'h00FF_00FF;
  localparam logic [31:0] W_SETUP   = 32'h0020_0020;
  localparam logic [31:0] W_CONFIRM = 32'h00D0_00D0;
  localparam logic [31:0] W_STATUS  = 32'h0070_0070;

  logic [1:0]        kindSeen;
  logic [31:0]       lastWr;
  logic [ADDR_W-1:0] lastAddr;
  logic              outstanding;
  logic [CNT_W-1:0]  statusWrites;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindSeen     <= 2'd0;
      lastWr       <= '0;
      lastAddr     <= '0;
      outstanding  <= 1'b0;
      statusWrites <= '0;
    end else begin
      if (opValid && !busy) begin
        kindSeen     <= opKind;
        statusWrites <= '0;
      end else if (busWr && kindSeen == 2'd1 && busWdata == W_STATUS &&
                   statusWrites != CNT_W'(POLL_LIMIT + 1)) begin
        statusWrites <= statusWrites + 1'b1;
      end
      if (busWr) begin
        lastWr   <= busWdata;
        lastAddr <= busAddr;
      end
      if (busWr || busRd) outstanding <= 1'b1;
      else if (busAck) outstanding <= 1'b0;
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (busWr || busRd) |=> !(busWr || busRd)); // R10
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busRd)); // R10
  AST_WAIT_FOR_ACK: assert property (@(posedge clk) disable iff (!rstN)
    outstanding |-> !(busWr || busRd)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(busWr || busRd)); // R1
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11
  AST_ENDS_IN_ARRAY: assert property (@(posedge clk) disable iff (!rstN)
    (done && kindSeen != 2'd3) |-> lastWr == W_ARRAY); // R6
  AST_CONFIRM_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && kindSeen == 2'd1 && busWdata == W_CONFIRM) |->
      (lastWr == W_SETUP && lastAddr == busAddr)); // R4
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    statusWrites <= CNT_W'(POLL_LIMIT)); // R9

endmodule

bind nor_cmd_sequencer nor_seq_checker #(.ADDR_W(ADDR_W), .POLL_LIMIT(POLL_LIMIT)) u_chk (.*);

// File: tb/nor_cmd_sequencer_test.sv
`timescale 1ns/1ps
module nor_cmd_sequencer_test;

  localparam int ADDR_W = 20;
  localparam int LIM    = 6;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              opValid = 1'b0;
  logic [1:0]        opKind = 2'd0;
  logic [ADDR_W-1:0] opAddr = '0;
  logic [31:0]       opData = '0;
  logic              busy, done, pass, busWr, busRd;
  logic [ADDR_W-1:0] busAddr;
  logic [31:0]       busWdata;
  logic [31:0]       busRdata = '0;
  logic              busAck = 1'b0;

  always #2.5 clk = ~clk;

  nor_cmd_sequencer #(.ADDR_W(ADDR_W), .POLL_LIMIT(LIM)) uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind), .opAddr(opAddr),
    .opData(opData), .busy(busy), .done(done), .pass(pass), .busAddr(busAddr),
    .busWdata(busWdata), .busWr(busWr), .busRd(busRd), .busRdata(busRdata),
    .busAck(busAck)
  );

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // simulated two-device flash
  int          cfgBusy = 0;
  logic [31:0] cfgErr = 0, cfgMan = 32'h0089_0089, cfgDev = 32'h88F3_88F3, cfgCorrupt = 0;
  logic [31:0] mem [16];
  int          fMode = 0, busyLeft = 0, dly = 0, protoErr = 0, logN = 0;
  bit          expData = 0;
  logic [31:0] pend = 0;
  bit          logW [64];
  logic [ADDR_W-1:0] logA [64];
  logic [31:0] logD [64];

  always @(negedge clk) begin
    busAck = 1'b0;
    if (dly > 0) begin
      dly--;
      if (dly == 0) begin busAck = 1'b1; busRdata = pend; end
    end
    if (busWr || busRd) begin
      if (dly > 0 || busAck || (busWr && busRd)) protoErr++;
      if (logN < 64) begin
        logW[logN] = busWr; logA[logN] = busAddr; logD[logN] = busWdata;
      end
      logN++;
      if (busWr) begin
        if (expData) begin
          mem[busAddr[3:0]] = busWdata ^ cfgCorrupt;
          busyLeft = cfgBusy; fMode = 2; expData = 0;
        end else begin
          case (busWdata)
            32'h00FF00FF: fMode = 0;
            32'h00900090: fMode = 1;
            32'h00400040: expData = 1;
            32'h00D000D0: begin mem[busAddr[3:0]] = '1; busyLeft = cfgBusy; fMode = 2; end
            32'h00700070: fMode = 2;
            default: ;
          endcase
        end
        pend = 32'hDEAD_BEEF;
      end else begin
        if (fMode == 0) pend = mem[busAddr[3:0]];
        else if (fMode == 1) pend = (busAddr == 0) ? cfgMan : (busAddr == 1) ? cfgDev : 32'h0;
        else if (busyLeft > 0) begin
          pend = busyLeft[0] ? 32'h0000_0080 : 32'h0080_0000;  // one half ready only
          busyLeft--;
        end else pend = 32'h0080_0080 | cfgErr;
      end
      dly = 1 + int'($urandom % 3);
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected transaction list
  int          expN;
  bit          expW [64];
  logic [ADDR_W-1:0] expA [64];
  logic [31:0] expD [64];

  function automatic void pushExp(input bit w, input logic [ADDR_W-1:0] a, input logic [31:0] d);
    if (expN < 64) begin expW[expN] = w; expA[expN] = a; expD[expN] = d; end
    expN++;
  endfunction

  function automatic void buildExp(input int k, input logic [ADDR_W-1:0] a, input logic [31:0] d);
    int reads;
    bit to;
    expN = 0;
    to = (cfgBusy >= LIM);
    reads = to ? LIM : cfgBusy + 1;
    if (k == 0) begin
      pushExp(1, 0, 32'h00900090); pushExp(0, 0, 0); pushExp(0, 1, 0); pushExp(1, 0, 32'h00FF00FF);
    end else if (k == 1 || k == 2) begin
      if (k == 1) begin pushExp(1, a, 32'h00200020); pushExp(1, a, 32'h00D000D0); end
      else begin pushExp(1, a, 32'h00400040); pushExp(1, a, d); end
      for (int i = 0; i < reads; i++) begin pushExp(1, a, 32'h00700070); pushExp(0, a, 0); end
      pushExp(1, a, 32'h00FF00FF);
      if (k == 2 && !to) pushExp(0, a, 0);
    end
  endfunction

  function automatic bit expPass(input int k);
    bit to;
    to = (cfgBusy >= LIM);
    case (k)
      0: return cfgMan == 32'h0089_0089 && (cfgDev == 32'h88F3_88F3 || cfgDev == 32'h88F4_88F4);
      1: return !to && (cfgErr & 32'h0020_0020) == 0;
      2: return !to && (cfgErr & 32'h0010_0010) == 0 && cfgCorrupt == 0;
      default: return 0;
    endcase
  endfunction

  task automatic runOp(input int k, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                       input bit inject, input string tag);
    int cyc, dones, firstBad;
    bit gotPass, seqOk, busySeen;
    logN = 0; protoErr = 0; dones = 0; gotPass = 0; busySeen = 1;
    buildExp(k, a, d);
    @(negedge clk);
    opValid = 1; opKind = 2'(k); opAddr = a; opData = d;
    @(negedge clk);
    opValid = 0;
    cyc = 0;
    while (dones == 0 && cyc < 3000) begin
      if (!busy) busySeen = 0;
      if (done) begin dones++; gotPass = pass; end
      if (inject && cyc == 4) begin opValid = 1; opKind = 2'((k + 1) % 3); opAddr = a ^ 4'h5; end
      if (inject && cyc == 5) opValid = 0;
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 3000) check(0, {tag, " watchdog"}, 32'(cyc), 0);
    repeat (4) begin
      if (done) dones++;
      @(negedge clk);
    end
    seqOk = (logN == expN);
    firstBad = -1;
    for (int i = 0; i < expN && i < 64 && seqOk; i++)
      if (logW[i] != expW[i] || logA[i] != expA[i] || (expW[i] && logD[i] != expD[i])) begin
        seqOk = 0; firstBad = i;
      end
    if (firstBad >= 0)
      check(0, {tag, " sequence R2 R4 R5 R6 R8 R9 entry"}, logD[firstBad], expD[firstBad]);
    else
      check(seqOk, {tag, " sequence length R2 R5 R9"}, 32'(logN), 32'(expN));
    check(gotPass == expPass(k), {tag, " result R3 R7 R8 R9 R12"}, 32'(gotPass), 32'(expPass(k)));
    check(protoErr == 0, {tag, " handshake R10"}, 32'(protoErr), 0);
    check(dones == 1 && busySeen && !busy, {tag, " single done, busy span R11"}, 32'(dones), 1);
  endtask

  task automatic setDev(input int busyN, input logic [31:0] err, input logic [31:0] corrupt);
    cfgBusy = busyN; cfgErr = err; cfgCorrupt = corrupt;
    cfgMan = 32'h0089_0089; cfgDev = 32'h88F3_88F3;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 16; i++) mem[i] = '1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !pass && !busWr && !busRd, "R1 during reset", {28'h0, busy, done, busWr, busRd}, 0);
    rstN = 1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !busWr && !busRd && logN == 0, "R1 after reset", 32'(logN), 0);

    // probe cases (R3)
    setDev(0, 0, 0);                runOp(0, 0, 0, 0, "R3 probe top id");
    cfgDev = 32'h88F4_88F4;         runOp(0, 0, 0, 0, "R3 probe bottom id");
    cfgDev = 32'h88F1_88F1;         runOp(0, 0, 0, 0, "R3 probe small part");
    cfgDev = 32'h0000_88F3;         runOp(0, 0, 0, 0, "R3 probe one half id");
    setDev(0, 0, 0); cfgMan = 32'h0089_0000; runOp(0, 0, 0, 0, "R3 probe bad maker");

    // erase (R4 R5 R7)
    setDev(0, 0, 0);                runOp(1, 7, 0, 0, "R4 erase immediate ready");
    setDev(3, 0, 0);                runOp(1, 9, 0, 0, "R5 erase half ready polls");
    setDev(1, 32'h0020_0000, 0);    runOp(1, 2, 0, 0, "R7 erase upper fault");
    setDev(1, 32'h0000_0020, 0);    runOp(1, 3, 0, 0, "R7 erase lower fault");
    setDev(0, 32'h0010_0010, 0);    runOp(1, 4, 0, 0, "R7 erase ignores program bit");

    // program (R8)
    setDev(2, 0, 0);                runOp(2, 5, 32'h1234_5678, 0, "R8 program ok");
    setDev(0, 0, 0);                runOp(2, 6, 32'h00FF_00FF, 0, "R8 program code-like data");
    setDev(0, 0, 0);                runOp(2, 8, 32'h00D0_00D0, 0, "R8 program confirm-like data");
    setDev(1, 0, 32'h0000_0100);    runOp(2, 1, 32'hA5A5_A5A5, 0, "R8 program readback mismatch");
    setDev(1, 32'h0010_0000, 0);    runOp(2, 10, 32'h0F0F_0F0F, 0, "R8 program upper fault");

    // timeout boundary (R9)
    setDev(LIM - 1, 0, 0);          runOp(1, 11, 0, 0, "R9 erase ready at last read");
    setDev(LIM, 0, 0);              runOp(1, 12, 0, 0, "R9 erase timeout");
    setDev(1000, 0, 0);             runOp(2, 13, 32'h5555_AAAA, 0, "R9 program hung device");

    // reserved kind and ignored request (R12 R11)
    setDev(0, 0, 0);                runOp(3, 0, 0, 0, "R12 reserved kind");
    setDev(2, 0, 0);                runOp(1, 14, 0, 1, "R11 request while busy erase");
    setDev(0, 0, 0);                runOp(0, 0, 0, 1, "R11 request while busy probe");

    // random mix
    for (int n = 0; n < 30; n++) begin
      int k, e;
      k = int'($urandom % 3);
      e = int'($urandom % 7);
      setDev(int'($urandom % 9),
             (e == 1) ? 32'h0020_0000 : (e == 2) ? 32'h0000_0020 :
             (e == 3) ? 32'h0010_0000 : (e == 4) ? 32'h0000_0010 : 32'h0,
             ($urandom % 5 == 0) ? (32'h1 << ($urandom % 32)) : 32'h0);
      if ($urandom % 4 == 0) cfgDev = 32'h88F4_88F4;
      if ($urandom % 6 == 0) cfgMan = 32'h0089_0088;
      runOp(k, ADDR_W'($urandom % 16), $urandom, ($urandom % 4 == 0), "random R3 R5 R7 R8 R9");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule